// File: doc/BRIEF.md
# Posit Normalize, Round and Encode Stage

This block is the back end of a fused dot-product datapath. It receives an unsigned accumulated magnitude with a sign and a signed exponent. The exponent gives the weight of the most significant magnitude bit, so the value is (-1)^sign * in_mag * 2^(in_exp - (MAG_W-1)). A NaR flag travels alongside the data. The first registered step counts leading zeros, shifts the leading one to the top and lowers the exponent by the shift amount.

The second registered step writes the result as a posit whose word size and exponent-field size are set by their own parameters. Those parameters do not depend on the width of the incoming data, so one accumulator can feed posit outputs of different precisions. Rounding happens once, at the output width, on the packed bit string. A saturating range guard keeps the result away from zero and NaR.

Each valid input produces one result exactly two cycles later. There is no flow control.

Top module: `posit_norm_encode`

## Requirements
- R1: While reset is asserted and after it is released with no valid input, out_valid is 0 and out_posit is all zeros.
- R2: out_valid equals in_valid from two clock cycles earlier, and out_posit carries the result of that input.
- R3: A zero magnitude without the NaR flag produces all zeros, whatever the sign and exponent are.
- R4: When the NaR flag is set, the output is a 1 followed by OUT_N-1 zeros (0x80 for 8 bits), whatever the other inputs are.
- R5: The value is normalized by its leading-zero count, giving scale = in_exp - lzc. With k = floor(scale/2^OUT_ES) and e = scale mod 2^OUT_ES, the body after the sign bit is: k+1 ones then a zero when k >= 0, or -k zeros then a one when k < 0. The OUT_ES bits of e follow, then the fraction bits below the leading one. For OUT_N=8 and OUT_ES=1, 1.0 gives 0x40, 2.0 gives 0x50 and 1.5 gives 0x48.
- R6: The body is truncated to OUT_N-1 bits and rounded to nearest, with ties going to even. Guard is the first dropped bit and sticky is the OR of all later bits. The body is incremented when guard & (lsb | sticky).
- R7: When k > OUT_N-2, the magnitude saturates to maxpos: a zero sign bit followed by all ones (0x7F for 8 bits).
- R8: When k < -(OUT_N-2), the magnitude saturates to minpos (0x01 for 8 bits). A nonzero value never encodes to zero or NaR.
- R9: A negative result is the two's complement of the positive encoding, so -1.0 gives 0xC0, -maxpos gives 0x81 and -minpos gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_sign | input | 1 | Sign of the accumulated value |
| in_mag | input | MAG_W | Unsigned accumulated magnitude |
| in_exp | input | EXP_W | Signed exponent of the most significant magnitude bit |
| in_nar | input | 1 | Input is Not-a-Real |
| out_valid | output | 1 | Result is valid |
| out_posit | output | OUT_N | Encoded posit result |

## Verification
The bench sweeps every magnitude, every exponent and both signs for an 8-bit, es=1 output. A design that rounds on value distance instead of on the bit string, or that ignores sticky bits, would give a wrong last bit on exact ties such as 0x84 and 0x8C near 1.0. Very large and very small exponents test saturation: a design without the guard would wrap the regime, or would round tiny values to zero. Negative values near the extremes show whether the two's complement is applied after rounding. Magnitudes with many leading zeros show whether the exponent follows the normalization shift.

// File: rtl/posit_norm_encode.sv
module posit_norm_encode #(
  parameter int MAG_W  = 16,
  parameter int EXP_W  = 8,
  parameter int OUT_N  = 16,
  parameter int OUT_ES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [EXP_W-1:0] in_exp,
  input  logic             in_nar,
  output logic             out_valid,
  output logic [OUT_N-1:0] out_posit
);
  localparam int LZ_W   = $clog2(MAG_W);
  localparam int SW     = EXP_W + LZ_W + 1;
  localparam int TAIL_W = 1 + OUT_ES + MAG_W - 1;
  localparam int L      = TAIL_W + OUT_N;
  localparam int K_TOP  = OUT_N - 2;

  logic [LZ_W-1:0] lz;
  always_comb begin
    lz = '0;
    for (int i = 0; i < MAG_W; i++)
      if (in_mag[i]) lz = LZ_W'(MAG_W - 1 - i);
  end

  logic [MAG_W-1:0] norm;
  logic signed [SW-1:0] scale_c;
  assign norm    = in_mag << lz;
  assign scale_c = $signed({{(SW-EXP_W){in_exp[EXP_W-1]}}, in_exp})
                 - $signed({{(SW-LZ_W){1'b0}}, lz});

  logic                 s1_valid, s1_sign, s1_zero, s1_nar;
  logic signed [SW-1:0] s1_scale;
  logic [MAG_W-2:0]     s1_frac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_zero  <= 1'b0;
      s1_nar   <= 1'b0;
      s1_scale <= '0;
      s1_frac  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sign  <= in_sign;
      s1_zero  <= (in_mag == '0);
      s1_nar   <= in_nar;
      s1_scale <= scale_c;
      s1_frac  <= norm[MAG_W-2:0];
    end
  end

  logic signed [SW-1:0] k;
  logic                 neg_k;
  logic [SW-1:0]        run;
  logic [TAIL_W-1:0]    tail;
  assign k     = s1_scale >>> OUT_ES;
  assign neg_k = k[SW-1];
  assign run   = neg_k ? SW'(-k) : SW'(k + 1);

  generate
    if (OUT_ES > 0) begin : g_exp
      assign tail = {neg_k, s1_scale[OUT_ES-1:0], s1_frac};
    end else begin : g_noexp
      assign tail = {neg_k, s1_frac};
    end
  endgenerate

  logic [L-1:0] placed, fill, str;
  assign placed = {tail, {OUT_N{1'b0}}} >> run;
  assign fill   = neg_k ? '0 : ~({L{1'b1}} >> run);
  assign str    = placed | fill;

  logic [OUT_N-2:0] body, body_r, mag_p;
  logic guard, sticky, sat_hi, sat_lo;
  assign body   = str[L-1 -: OUT_N-1];
  assign guard  = str[L-OUT_N];
  assign sticky = |str[L-OUT_N-1:0];
  assign body_r = body + {{(OUT_N-2){1'b0}}, guard & (body[0] | sticky)};
  assign sat_hi = int'(k) > K_TOP;
  assign sat_lo = int'(k) < -K_TOP;
  assign mag_p  = sat_hi ? '1 : sat_lo ? {{(OUT_N-2){1'b0}}, 1'b1} : body_r;

  logic [OUT_N-1:0] pos, result;
  assign pos    = {1'b0, mag_p};
  assign result = s1_nar  ? {1'b1, {(OUT_N-1){1'b0}}} :
                  s1_zero ? '0 :
                  s1_sign ? (~pos + 1'b1) : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_posit <= '0;
    end else begin
      out_valid <= s1_valid;
      out_posit <= result;
    end
  end
endmodule

module posit_norm_encode_chk #(
  parameter int OUT_N = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_N-1:0] out_posit,
  input logic             s1_valid,
  input logic             s1_zero,
  input logic             s1_nar,
  input logic             s1_sign
);
  localparam logic [OUT_N-1:0] NAR = {1'b1, {(OUT_N-1){1'b0}}};
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
  a_r4_nar_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_nar) |=> (out_posit == NAR));
  a_r3_zero_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_zero && !s1_nar) |=> (out_posit == '0));
  a_r8_never_zero_or_nar: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_zero && !s1_nar) |=> (out_posit != '0 && out_posit != NAR));
  a_r9_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_zero && !s1_nar) |=> (out_posit[OUT_N-1] == $past(s1_sign)));
endmodule

bind posit_norm_encode posit_norm_encode_chk #(.OUT_N(OUT_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_posit(out_posit), .s1_valid(s1_valid), .s1_zero(s1_zero),
  .s1_nar(s1_nar), .s1_sign(s1_sign)
);

// File: tb/posit_norm_encode_bench.sv
module posit_norm_encode_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0, in_nar = 1'b0;
  logic [7:0] in_mag = '0;
  logic [5:0] in_exp = '0;
  logic out_valid;
  logic [7:0] out_posit;

  always #4 clk = ~clk;

  posit_norm_encode #(.MAG_W(8), .EXP_W(6), .OUT_N(8), .OUT_ES(1)) u_posit_norm_encode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .in_exp(in_exp), .in_nar(in_nar),
    .out_valid(out_valid), .out_posit(out_posit)
  );

  int nchk = 0, nerr = 0;
  bit pv[2];
  logic [7:0] pe[2];
  string pt[2];

  function automatic logic [7:0] ref_enc(bit s, int m, int ex, bit n);
    int p, scale, k, e, cnt;
    bit b[64];
    logic [6:0] body;
    logic [7:0] pos;
    bit g, st;
    if (n) return 8'h80;
    if (m == 0) return 8'h00;
    p = 0;
    for (int i = 0; i < 8; i++) if (m[i]) p = i;
    scale = ex - (7 - p);
    k = (scale >= 0) ? scale / 2 : (scale - 1) / 2;
    e = scale - 2 * k;
    if (k > 6) body = 7'h7F;
    else if (k < -6) body = 7'h01;
    else begin
      for (int i = 0; i < 64; i++) b[i] = 1'b0;
      cnt = 0;
      if (k >= 0) begin
        for (int i = 0; i <= k; i++) begin b[cnt] = 1'b1; cnt++; end
        b[cnt] = 1'b0; cnt++;
      end else begin
        for (int i = 0; i < -k; i++) begin b[cnt] = 1'b0; cnt++; end
        b[cnt] = 1'b1; cnt++;
      end
      b[cnt] = e[0]; cnt++;
      for (int i = p - 1; i >= 0; i--) begin b[cnt] = m[i]; cnt++; end
      for (int i = 0; i < 7; i++) body[6-i] = b[i];
      g = b[7];
      st = 1'b0;
      for (int i = 8; i < 64; i++) st = st | b[i];
      if (g && (body[0] || st)) body = body + 7'd1;
    end
    pos = {1'b0, body};
    return s ? (~pos + 8'd1) : pos;
  endfunction

  task automatic step(bit v, bit s, int m, int ex, bit n, string tg);
    @(negedge clk);
    nchk++;
    if (out_valid !== pv[1]) begin
      nerr++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, pv[1]);
    end
    if (pv[1]) begin
      nchk++;
      if (out_posit !== pe[1]) begin
        nerr++;
        $display("FAIL %s out_posit actual=%02h expected=%02h", pt[1], out_posit, pe[1]);
      end
    end
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    pv[0] = v; pe[0] = ref_enc(s, m, ex, n); pt[0] = tg;
    in_valid = v; in_sign = s; in_mag = 8'(m); in_exp = 6'(ex); in_nar = n;
  endtask

  task automatic expect_const(logic [7:0] got_exp, logic [7:0] want, string tg);
    nchk++;
    if (got_exp !== want) begin
      nerr++;
      $display("FAIL %s hand value actual=%02h expected=%02h", tg, got_exp, want);
    end
  endtask

  bit done = 1'b0;

  initial begin
    pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = '0; pe[1] = '0; pt[0] = ""; pt[1] = "";
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0 || out_posit !== 8'h00) begin
      nerr++;
      $display("FAIL R1 during reset actual=%0b/%02h expected=0/00", out_valid, out_posit);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0 || out_posit !== 8'h00) begin
      nerr++;
      $display("FAIL R1 after reset actual=%0b/%02h expected=0/00", out_valid, out_posit);
    end

    expect_const(ref_enc(0, 8'h80, 0, 0), 8'h40, "R5");
    expect_const(ref_enc(0, 8'h80, 1, 0), 8'h50, "R5");
    expect_const(ref_enc(0, 8'hC0, 0, 0), 8'h48, "R5");
    expect_const(ref_enc(0, 8'h84, 0, 0), 8'h40, "R6");
    expect_const(ref_enc(0, 8'h8C, 0, 0), 8'h42, "R6");
    expect_const(ref_enc(0, 8'h85, 0, 0), 8'h41, "R6");
    expect_const(ref_enc(1, 8'h80, 0, 0), 8'hC0, "R9");

    step(1, 0, 8'h80, 0, 0, "R5");
    step(1, 0, 8'h01, 7, 0, "R5");
    step(1, 0, 8'h80, 1, 0, "R5");
    step(1, 0, 8'hC0, 0, 0, "R5");
    step(1, 0, 8'h84, 0, 0, "R6");
    step(1, 0, 8'h8C, 0, 0, "R6");
    step(1, 0, 8'h85, 0, 0, "R6");
    step(1, 1, 8'h80, 0, 0, "R9");
    step(1, 0, 8'hFF, 31, 0, "R7");
    step(1, 1, 8'hFF, 31, 0, "R9");
    step(1, 0, 8'h01, -32, 0, "R8");
    step(1, 1, 8'h01, -32, 0, "R9");
    step(1, 0, 8'h00, 5, 0, "R3");
    step(1, 1, 8'h00, -3, 0, "R3");
    step(1, 1, 8'h37, 4, 1, "R4");
    step(1, 0, 8'h00, 0, 1, "R4");
    step(0, 0, 8'h80, 0, 0, "R2");
    step(1, 0, 8'hA0, 2, 0, "R5");
    step(0, 1, 8'h11, 0, 0, "R2");

    for (int s = 0; s < 2; s++)
      for (int ex = -32; ex < 32; ex++)
        for (int m = 0; m < 256; m++)
          step((m % 7) != 3, s[0], m, ex, (m % 97) == 13,
               (m % 97) == 13 ? "R4" : (m == 0 ? "R3" : (s == 1 ? "R9" : "R6")));
    repeat (3) step(0, 0, 0, 0, 0, "R2");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule